// File: doc/BRIEF.md
# Pseudo-Random Noise Channel Generator

This block makes the pseudo-random bit stream for the noise voice of a sound generator. A 15-bit linear feedback shift register steps once each time a down-counting period timer expires. The timer reload value comes from one of three region tables, and a 4-bit period index picks the entry. A mode input switches the feedback tap, so the register runs either the long 32767-step sequence or a short looping one.

The envelope and length logic live outside this block. Here they appear only as a 4-bit volume input and an active flag. The output is the current noise bit and a gated 4-bit sample. A small state machine controls the timer. `SEQ_LOAD` is entered after reset and preloads the timer. It then moves to `SEQ_RUN` on the transition named *arm*. `SEQ_RUN` loops on itself. Each cycle it either counts down (transition *count*) or expires, shifts and reloads (transition *expire*).

Top module: `noise_chan`

## Requirements
- R1: On each timer expiry the register shifts right by one place, and the feedback bit enters bit 14. Bits 13..0 take the old bits 14..1.
- R2: The feedback bit is bit 0 XOR bit 1 when `mode_short` is 0, and bit 0 XOR bit 6 when `mode_short` is 1. The register holds 15 bits only.
- R3: Reset leaves the register at value 1. In that state `noise_bit` is 1 and `sample` is 0. The register never reaches all zeros.
- R4: The first cycle after reset is `SEQ_LOAD`, which loads the timer with the table period P. The first shift then happens P cycles later, and later shifts follow every P cycles, where P is the period in force at each reload.
- R5: Period tables by `region`. Code 0 and code 3: 4,8,16,32,64,96,128,160,202,254,380,508,762,1016,2034,4068. Code 1: 4,8,14,30,60,88,118,148,188,236,354,472,708,944,1890,3778. Code 2: 4,6,10,20,40,60,80,100,126,158,238,318,476,636,1270,2542. The entry is selected by `period_idx`, and a change takes effect at the next reload.
- R6: A change of `mode_short` does not clear or alter the register. It takes effect on the next shift only.
- R7: The register does not change in any cycle without an expiry.
- R8: `noise_bit` equals register bit 0. `sample` equals `vol` when bit 0 is 0 and `active` is 1, and is 0 otherwise. `sample` reacts combinationally to `vol` and `active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| mode_short | input | 1 | 1 selects the short sequence (tap bit 6) |
| period_idx | input | 4 | period table index |
| region | input | 2 | period table select |
| vol | input | 4 | volume from the envelope |
| active | input | 1 | channel enabled by the length logic |
| noise_bit | output | 1 | current register bit 0 |
| sample | output | 4 | gated volume sample |

## Verification
The bench checks the timing of the first shift after reset. A timer that skipped the load cycle, or that reloaded one early, would put every later bit one phase off. It also switches the mode while a sequence is running. A design that reset the register on a mode change, or that used the wrong tap, would produce a different bit stream at the next shift. Period index changes in the middle of a countdown must only apply at the next reload, and region code 3 must act as code 0. The bench also checks the gating of `sample` against `active` and bit 0, and the register must never reach zero.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int LFSR_W = 15;
    localparam int CNT_W  = 12;
    localparam int IDX_W  = 4;

    typedef enum logic [0:0] {
        SEQ_LOAD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [CNT_W-1:0] period_lookup(input logic [1:0] reg_sel,
                                                       input logic [IDX_W-1:0] idx);
        logic [CNT_W-1:0] p;
        p = '0;
        unique case (reg_sel)
            2'd1: begin
                unique case (idx)
                    4'd0:  p = 12'd4;    4'd1:  p = 12'd8;
                    4'd2:  p = 12'd14;   4'd3:  p = 12'd30;
                    4'd4:  p = 12'd60;   4'd5:  p = 12'd88;
                    4'd6:  p = 12'd118;  4'd7:  p = 12'd148;
                    4'd8:  p = 12'd188;  4'd9:  p = 12'd236;
                    4'd10: p = 12'd354;  4'd11: p = 12'd472;
                    4'd12: p = 12'd708;  4'd13: p = 12'd944;
                    4'd14: p = 12'd1890; 4'd15: p = 12'd3778;
                    default: p = 12'd4;
                endcase
            end
            2'd2: begin
                unique case (idx)
                    4'd0:  p = 12'd4;    4'd1:  p = 12'd6;
                    4'd2:  p = 12'd10;   4'd3:  p = 12'd20;
                    4'd4:  p = 12'd40;   4'd5:  p = 12'd60;
                    4'd6:  p = 12'd80;   4'd7:  p = 12'd100;
                    4'd8:  p = 12'd126;  4'd9:  p = 12'd158;
                    4'd10: p = 12'd238;  4'd11: p = 12'd318;
                    4'd12: p = 12'd476;  4'd13: p = 12'd636;
                    4'd14: p = 12'd1270; 4'd15: p = 12'd2542;
                    default: p = 12'd4;
                endcase
            end
            default: begin
                unique case (idx)
                    4'd0:  p = 12'd4;    4'd1:  p = 12'd8;
                    4'd2:  p = 12'd16;   4'd3:  p = 12'd32;
                    4'd4:  p = 12'd64;   4'd5:  p = 12'd96;
                    4'd6:  p = 12'd128;  4'd7:  p = 12'd160;
                    4'd8:  p = 12'd202;  4'd9:  p = 12'd254;
                    4'd10: p = 12'd380;  4'd11: p = 12'd508;
                    4'd12: p = 12'd762;  4'd13: p = 12'd1016;
                    4'd14: p = 12'd2034; 4'd15: p = 12'd4068;
                    default: p = 12'd4;
                endcase
            end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/noise_timer.sv
module noise_timer
    import noise_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    region,
    input  logic [IW-1:0] period_idx,
    output logic          expire,
    output logic [CW-1:0] count
);
    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] reload;
    logic          fire;

    assign reload = CW'(period_lookup(region, period_idx));

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_LOAD: state_d = SEQ_RUN;   // arm
            SEQ_RUN:  state_d = SEQ_RUN;   // count / expire
            default:  state_d = SEQ_LOAD;
        endcase
    end

    // output / datapath process
    always_comb begin
        fire  = 1'b0;
        cnt_d = cnt_q;
        unique case (state_q)
            SEQ_LOAD: cnt_d = reload;
            SEQ_RUN: begin
                if (cnt_q == CW'(1)) begin
                    fire  = 1'b1;
                    cnt_d = reload;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign expire = fire;
    assign count  = cnt_q;
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
#(
    parameter int W      = LFSR_W,
    parameter int TAP_LO = 1,
    parameter int TAP_HI = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         mode_short,
    output logic [W-1:0] value
);
    logic [W-1:0] sr_q;
    logic         tap;

    assign tap = mode_short ? sr_q[TAP_HI] : sr_q[TAP_LO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= W'(1);
        end else if (step) begin
            sr_q <= {sr_q[0] ^ tap, sr_q[W-1:1]};
        end
    end

    assign value = sr_q;
endmodule

// File: rtl/noise_gate.sv
module noise_gate #(
    parameter int VW = 4
) (
    input  logic          bit0,
    input  logic          active,
    input  logic [VW-1:0] vol,
    output logic [VW-1:0] sample
);
    always_comb begin
        sample = '0;
        if (!bit0 && active) sample = vol;
    end
endmodule

// File: rtl/noise_chan.sv
module noise_chan
    import noise_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_short,
    input  logic [3:0] period_idx,
    input  logic [1:0] region,
    input  logic [3:0] vol,
    input  logic       active,
    output logic       noise_bit,
    output logic [3:0] sample
);
    logic              expire;
    logic [CNT_W-1:0]  count;
    logic [LFSR_W-1:0] lfsr;

    noise_timer #(.CW(CNT_W), .IW(IDX_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .region(region), .period_idx(period_idx),
        .expire(expire), .count(count)
    );

    noise_lfsr #(.W(LFSR_W), .TAP_LO(1), .TAP_HI(6)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(expire), .mode_short(mode_short),
        .value(lfsr)
    );

    noise_gate #(.VW(4)) u_gate (
        .bit0(lfsr[0]), .active(active), .vol(vol), .sample(sample)
    );

    assign noise_bit = lfsr[0];
endmodule

// File: rtl/noise_chan_chk.sv
module noise_chan_chk
    import noise_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_short,
    input logic [3:0]        period_idx,
    input logic [1:0]        region,
    input logic [3:0]        vol,
    input logic              active,
    input logic [3:0]        sample,
    input logic              expire,
    input logic [CNT_W-1:0]  count,
    input logic [LFSR_W-1:0] lfsr
);
    a_r1_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> lfsr[13:0] == $past(lfsr[14:1]));

    a_r2_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> lfsr[14] == ($past(lfsr[0]) ^
                   ($past(mode_short) ? $past(lfsr[6]) : $past(lfsr[1]))));

    a_r3_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == $past(period_lookup(region, period_idx)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> $stable(lfsr));

    a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr[0] || !active) |-> sample == 4'd0);

    a_r8_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!lfsr[0] && active) |-> sample == vol);
endmodule

bind noise_chan noise_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_short(mode_short), .period_idx(period_idx),
    .region(region), .vol(vol), .active(active), .sample(sample),
    .expire(expire), .count(count), .lfsr(lfsr)
);

// File: tb/sim_noise_chan.sv
module sim_noise_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_short = 1'b0;
    logic [3:0] period_idx = 4'd0;
    logic [1:0] region = 2'd0;
    logic [3:0] vol = 4'd9;
    logic       active = 1'b1;
    logic       noise_bit;
    logic [3:0] sample;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    noise_chan u0 (
        .clk(clk), .rst_n(rst_n), .mode_short(mode_short), .period_idx(period_idx),
        .region(region), .vol(vol), .active(active), .noise_bit(noise_bit),
        .sample(sample)
    );

    function automatic int ref_period(input logic [1:0] r, input logic [3:0] i);
        int t0[16] = '{4,8,16,32,64,96,128,160,202,254,380,508,762,1016,2034,4068};
        int t1[16] = '{4,8,14,30,60,88,118,148,188,236,354,472,708,944,1890,3778};
        int t2[16] = '{4,6,10,20,40,60,80,100,126,158,238,318,476,636,1270,2542};
        if (r == 2'd1) return t1[i];
        if (r == 2'd2) return t2[i];
        return t0[i];
    endfunction

    // reference model built from the requirements
    logic [14:0] m_sr;
    int          m_cnt;
    bit          m_loaded;
    int          m_shifts;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr <= 15'd1; m_cnt <= 0; m_loaded <= 0; m_shifts <= 0;
        end else if (!m_loaded) begin
            m_cnt <= ref_period(region, period_idx); m_loaded <= 1;
        end else if (m_cnt == 1) begin
            m_sr <= {m_sr[0] ^ (mode_short ? m_sr[6] : m_sr[1]), m_sr[14:1]};
            m_cnt <= ref_period(region, period_idx);
            m_shifts <= m_shifts + 1;
        end else begin
            m_cnt <= m_cnt - 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_sample(input logic [14:0] sr);
        return (!sr[0] && active) ? int'(vol) : 0;
    endfunction

    task automatic step_check(input string req);
        @(negedge clk);
        check(req, noise_bit, m_sr[0]);
        check("R8", sample, exp_sample(m_sr));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R3: reset state
        check("R3", noise_bit, 1);
        check("R3", sample, 0);
        rst_n = 1'b1;
        // R4: first shift exactly P=4 cycles after the load cycle
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R4", noise_bit, (k < 4) ? 1 : 0);
        end
        check("R1", m_shifts, 1);
        check("R8", sample, 9);
        // R8: sample follows vol/active combinationally
        active = 1'b0; #0.5;
        check("R8", sample, 0);
        active = 1'b1; vol = 4'd3; #0.5;
        check("R8", sample, 3);
        // R1 R2 long mode, directed
        for (int k = 0; k < 200; k++) step_check("R1");
        // R6: switch to short mode mid-run, register not cleared
        mode_short = 1'b1;
        for (int k = 0; k < 200; k++) step_check("R6");
        // R5: region 3 behaves as region 0; period change mid-countdown
        region = 2'd3; period_idx = 4'd2;
        for (int k = 0; k < 150; k++) step_check("R5");
        period_idx = 4'd0;
        for (int k = 0; k < 60; k++) step_check("R5");
        // random mix
        for (int blk = 0; blk < 300; blk++) begin
            mode_short = 1'($urandom);
            region     = 2'($urandom);
            period_idx = 4'($urandom_range(0, 5));
            vol        = 4'($urandom);
            active     = ($urandom_range(0, 3) != 0);
            for (int k = 0; k < 80; k++) step_check("R2");
        end
        // R7: long period, output stable between shifts
        region = 2'd0; period_idx = 4'd15;
        for (int k = 0; k < 9000; k++) step_check("R7");
        // R3: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R3", noise_bit, 1);
        check("R3", sample, 0);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule